// File: doc/BRIEF.md
# Bit-Sliced Integer ALU with Set-Less-Than

This block is a purely combinational integer ALU of parameterised width, built by repeating a single one-bit slice. Each slice can complement either operand bit and contains a full adder. A two-bit selector then chooses one slice result: the AND of the operand bits, their OR, the adder sum, or a side input called "less". The carries ripple from bit 0 upwards. The carry into bit 0 equals the B-complement control, so one adder handles both addition and two's-complement subtraction.

Two operations come from reusing the slices rather than adding logic. Set-less-than takes the sum bit of the top slice, which is the sign of A minus B, and feeds it back into the less input of bit 0. The less inputs of all other slices are held at zero. NOR complements both operands and selects AND. A datapath drives the four control bits (A-complement, B-complement, two-bit selector) and reads the result with the carry, signed-overflow and all-zero flags.

Top module: `alu_bitslice`

## Requirements
- R1: With control {a_inv_i,b_inv_i,op_i} = 0_0_00, result_o equals a_i AND b_i.
- R2: With control 0_0_01, result_o equals a_i OR b_i.
- R3: With control 0_0_10, result_o equals (a_i + b_i) modulo 2^WIDTH. carry_o is bit WIDTH of the unsigned sum.
- R4: With control 0_1_10, result_o equals (a_i - b_i) modulo 2^WIDTH, formed as a_i + ~b_i + 1. carry_o is 1 exactly when a_i >= b_i, read as unsigned values.
- R5: With control 0_1_11, result_o bit 0 equals the most significant bit of (a_i - b_i) modulo 2^WIDTH. When that subtraction does not overflow in signed terms, bit 0 is 1 exactly when a_i < b_i as signed values.
- R6: With control 1_1_00, result_o equals NOT (a_i OR b_i).
- R7: With op_i = 11, result_o bits WIDTH-1 down to 1 are all 0.
- R8: For add (0_0_10) and subtract (0_1_10), ovf_o is 1 exactly when the signed two's-complement result does not fit in WIDTH bits.
- R9: For every control value, zero_o is 1 exactly when every bit of result_o is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | WIDTH | Operand A |
| b_i | input | WIDTH | Operand B |
| a_inv_i | input | 1 | Complement A before the slice logic |
| b_inv_i | input | 1 | Complement B and carry 1 into bit 0 |
| op_i | input | 2 | Slice selector: 00 AND, 01 OR, 10 sum, 11 less |
| result_o | output | WIDTH | Selected result |
| carry_o | output | 1 | Carry out of the top slice |
| ovf_o | output | 1 | Carry into top slice XOR carry out of it |
| zero_o | output | 1 | 1 when result_o is all zeros |

## Verification
The block has no registers, so every output is due in the same time step as the input change that causes it, and no output is due a clock cycle later. After each new operand and control pattern, the bench waits a fixed settling delay that falls between clock edges, and only then samples. A 4-bit instance is swept over every operand pair and all six control codes. A 32-bit instance is driven with corner operands (zero, all ones, maximum positive, minimum negative, equal pairs) and with pseudo-random pairs. All expected values come from integer arithmetic in the bench.

// File: rtl/alu_bitslice_pkg.sv
package alu_bitslice_pkg;

  // Slice result selector; the code values are part of the control word.
  typedef enum logic [1:0] {
    SEL_AND  = 2'b00,
    SEL_OR   = 2'b01,
    SEL_SUM  = 2'b10,
    SEL_LESS = 2'b11
  } sel_e;

endpackage

// File: rtl/alu_slice.sv
module alu_slice
  import alu_bitslice_pkg::*;
#(
  parameter bit IS_TOP = 1'b0
) (
  input  logic a_i,
  input  logic b_i,
  input  logic a_inv_i,
  input  logic b_inv_i,
  input  sel_e sel_i,
  input  logic cin_i,
  input  logic less_i,
  output logic res_o,
  output logic cout_o,
  output logic sum_o,
  output logic ovf_o
);

  logic a_eff;
  logic b_eff;

  always_comb begin
    a_eff  = a_i ^ a_inv_i;
    b_eff  = b_i ^ b_inv_i;
    sum_o  = a_eff ^ b_eff ^ cin_i;
    cout_o = (a_eff & b_eff) | (cin_i & (a_eff ^ b_eff));
    unique case (sel_i)
      SEL_AND:  res_o = a_eff & b_eff;
      SEL_OR:   res_o = a_eff | b_eff;
      SEL_SUM:  res_o = sum_o;
      SEL_LESS: res_o = less_i;
      default:  res_o = 1'b0;
    endcase
  end

  // Only the top slice carries the signed overflow detector.
  generate
    if (IS_TOP) begin : g_ovf
      assign ovf_o = cin_i ^ cout_o;
    end else begin : g_no_ovf
      assign ovf_o = 1'b0;
    end
  endgenerate

endmodule

// File: rtl/alu_zero_detect.sv
module alu_zero_detect #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] vec_i,
  output logic             zero_o
);

  assign zero_o = ~|vec_i;

endmodule

// File: rtl/alu_bitslice.sv
module alu_bitslice
  import alu_bitslice_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             a_inv_i,
  input  logic             b_inv_i,
  input  logic [1:0]       op_i,
  output logic [WIDTH-1:0] result_o,
  output logic             carry_o,
  output logic             ovf_o,
  output logic             zero_o
);

  localparam int TOP = WIDTH - 1;

  sel_e             sel;
  logic [WIDTH:0]   carry;
  logic [WIDTH-1:0] less;
  logic [WIDTH-1:0] sum;
  logic [WIDTH-1:0] ovf;
  logic             set_bit;

  assign sel      = sel_e'(op_i);
  assign carry[0] = b_inv_i;
  assign set_bit  = sum[TOP];

  // Bit 0 receives the sign of the top adder; every other slice reads zero.
  assign less = {{(WIDTH-1){1'b0}}, set_bit};

  generate
    for (genvar i = 0; i < WIDTH; i++) begin : g_slice
      alu_slice #(.IS_TOP(i == TOP)) u_slice (
        .a_i     (a_i[i]),
        .b_i     (b_i[i]),
        .a_inv_i (a_inv_i),
        .b_inv_i (b_inv_i),
        .sel_i   (sel),
        .cin_i   (carry[i]),
        .less_i  (less[i]),
        .res_o   (result_o[i]),
        .cout_o  (carry[i+1]),
        .sum_o   (sum[i]),
        .ovf_o   (ovf[i])
      );
    end
  endgenerate

  assign carry_o = carry[WIDTH];
  assign ovf_o   = ovf[TOP];

  alu_zero_detect #(.WIDTH(WIDTH)) u_zero (
    .vec_i  (result_o),
    .zero_o (zero_o)
  );

endmodule

// File: rtl/alu_bitslice_chk.sv
module alu_bitslice_chk #(
  parameter int WIDTH = 32
) (
  input logic [WIDTH-1:0] a_i,
  input logic [WIDTH-1:0] b_i,
  input logic             a_inv_i,
  input logic             b_inv_i,
  input logic [1:0]       op_i,
  input logic [WIDTH-1:0] result_o,
  input logic             carry_o,
  input logic             ovf_o,
  input logic             zero_o
);

  logic [WIDTH-1:0] ae;
  logic [WIDTH-1:0] be;
  logic [WIDTH:0]   wide_add;

  always_comb begin
    ae       = a_inv_i ? ~a_i : a_i;
    be       = b_inv_i ? ~b_i : b_i;
    wide_add = {1'b0, a_i} + {1'b0, b_i};

    a_r9_zero_flag: assert (zero_o == (result_o == '0))
      else $error("R9 zero flag disagrees with result");

    if (op_i == 2'b11) begin
      a_r7_less_upper_clear: assert (result_o[WIDTH-1:1] == '0)
        else $error("R7 upper bits set under less select");
    end

    if (op_i == 2'b00) begin
      a_r1_and_select: assert (result_o == (ae & be))
        else $error("R1/R6 AND path mismatch");
    end

    if (op_i == 2'b01) begin
      a_r2_or_select: assert (result_o == (ae | be))
        else $error("R2 OR path mismatch");
    end

    if (op_i == 2'b10 && !a_inv_i && !b_inv_i) begin
      a_r3_add_carry: assert ({carry_o, result_o} == wide_add)
        else $error("R3 add mismatch");
    end

    if (op_i == 2'b10 && !a_inv_i) begin
      a_r8_signed_ovf: assert (ovf_o ==
          ((a_i[WIDTH-1] == be[WIDTH-1]) && (result_o[WIDTH-1] != a_i[WIDTH-1])))
        else $error("R8 overflow mismatch");
    end
  end

endmodule

bind alu_bitslice alu_bitslice_chk #(.WIDTH(WIDTH)) u_chk (
  .a_i      (a_i),
  .b_i      (b_i),
  .a_inv_i  (a_inv_i),
  .b_inv_i  (b_inv_i),
  .op_i     (op_i),
  .result_o (result_o),
  .carry_o  (carry_o),
  .ovf_o    (ovf_o),
  .zero_o   (zero_o)
);

// File: tb/test_alu_bitslice.sv
`timescale 1ns/1ps
module test_alu_bitslice;

  localparam int WB = 32;
  localparam int WS = 4;

  logic clk;
  logic rst_n;
  int   total;
  int   bad;
  bit   finished;

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // Wide instance
  logic [WB-1:0] a_b, b_b, r_b;
  logic          ai_b, bi_b, c_b, v_b, z_b;
  logic [1:0]    op_b;

  alu_bitslice #(.WIDTH(WB)) i_alu_bitslice (
    .a_i(a_b), .b_i(b_b), .a_inv_i(ai_b), .b_inv_i(bi_b), .op_i(op_b),
    .result_o(r_b), .carry_o(c_b), .ovf_o(v_b), .zero_o(z_b)
  );

  // Small instance for the exhaustive sweep
  logic [WS-1:0] a_s, b_s, r_s;
  logic          ai_s, bi_s, c_s, v_s, z_s;
  logic [1:0]    op_s;

  alu_bitslice #(.WIDTH(WS)) i_alu_bitslice_small (
    .a_i(a_s), .b_i(b_s), .a_inv_i(ai_s), .b_inv_i(bi_s), .op_i(op_s),
    .result_o(r_s), .carry_o(c_s), .ovf_o(v_s), .zero_o(z_s)
  );

  task automatic check(input string req, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // Expected outputs from integer arithmetic, per control code index:
  // 0 and, 1 or, 2 add, 3 sub, 4 slt, 5 nor
  task automatic expect_all(input int w, input int k, input longint a, input longint b,
                            output longint res, output longint cy,
                            output longint ov, output longint zr);
    longint mask, half, sa, sb, diff, full;
    mask = (longint'(1) << w) - 1;
    half = longint'(1) << (w - 1);
    sa = (a >= half) ? a - (longint'(1) << w) : a;
    sb = (b >= half) ? b - (longint'(1) << w) : b;
    cy = 0; ov = 0;
    diff = (a - b) & mask;
    case (k)
      0: res = a & b;
      1: res = a | b;
      2: begin
           full = a + b;
           res = full & mask;
           cy = (full > mask) ? 1 : 0;
           ov = ((sa + sb) >= half || (sa + sb) < -half) ? 1 : 0;
         end
      3: begin
           res = diff;
           cy = (a >= b) ? 1 : 0;
           ov = ((sa - sb) >= half || (sa - sb) < -half) ? 1 : 0;
         end
      4: begin
           res = (diff >= half) ? 1 : 0;
           cy = (a >= b) ? 1 : 0;
         end
      default: begin
           res = ~(a | b) & mask;
           cy = ((((~a) & mask) + ((~b) & mask) + 1) > mask) ? 1 : 0;
         end
    endcase
    zr = (res == 0) ? 1 : 0;
  endtask

  function automatic logic [3:0] code_of(input int k);
    case (k)
      0: return 4'b0000;
      1: return 4'b0001;
      2: return 4'b0010;
      3: return 4'b0110;
      4: return 4'b0111;
      default: return 4'b1100;
    endcase
  endfunction

  function automatic string req_of(input int k);
    case (k)
      0: return "R1";
      1: return "R2";
      2: return "R3";
      3: return "R4";
      4: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic compare(input int w, input int k, input longint a, input longint b,
                         input longint res, input longint cy, input longint ov,
                         input longint zr);
    longint er, ec, ev, ez;
    expect_all(w, k, a, b, er, ec, ev, ez);
    check(req_of(k), res, er);
    if (k == 2) check("R3 carry", cy, ec);
    if (k == 3) check("R4 carry", cy, ec);
    if (k == 2 || k == 3) check("R8 ovf", ov, ev);
    if (k == 4) check("R7 upper", res >> 1, 0);
    check("R9 zero", zr, ez);
  endtask

  task automatic apply_big(input int k, input logic [WB-1:0] a, input logic [WB-1:0] b);
    logic [3:0] c;
    longint sa, sb;
    c = code_of(k);
    @(posedge clk);
    #2;
    a_b = a; b_b = b; {ai_b, bi_b, op_b} = c;
    #2;
    compare(WB, k, longint'(a), longint'(b),
            longint'(r_b), longint'(c_b), longint'(v_b), longint'(z_b));
    // R5: signed comparison holds whenever the subtraction does not overflow
    if (k == 4) begin
      sa = longint'($signed(a)); sb = longint'($signed(b));
      if (!((sa - sb) >= (longint'(1) << (WB-1)) || (sa - sb) < -(longint'(1) << (WB-1))))
        check("R5 signed", longint'(r_b[0]), (sa < sb) ? 1 : 0);
    end
  endtask

  initial begin
    #200000;
    $display("FAIL watchdog expired");
    bad++;
    total++;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [WB-1:0] corners [6];
    logic [WB-1:0] lfsr_a, lfsr_b;
    total = 0; bad = 0; finished = 0;
    rst_n = 1'b0;
    a_b = '0; b_b = '0; ai_b = 0; bi_b = 0; op_b = 2'b00;
    a_s = '0; b_s = '0; ai_s = 0; bi_s = 0; op_s = 2'b00;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    #2;
    // Quiescent state: AND of zeros gives a zero result with the zero flag set
    check("R1 idle result", longint'(r_b), 0);
    check("R9 idle zero", longint'(z_b), 1);

    // Exhaustive sweep of the narrow instance
    for (int k = 0; k < 6; k++) begin
      for (int a = 0; a < (1 << WS); a++) begin
        for (int b = 0; b < (1 << WS); b++) begin
          a_s = WS'(a); b_s = WS'(b); {ai_s, bi_s, op_s} = code_of(k);
          #1;
          compare(WS, k, longint'(a), longint'(b),
                  longint'(r_s), longint'(c_s), longint'(v_s), longint'(z_s));
        end
      end
    end

    // Corner operands on the wide instance
    corners[0] = '0;
    corners[1] = '1;
    corners[2] = {1'b0, {(WB-1){1'b1}}};
    corners[3] = {1'b1, {(WB-1){1'b0}}};
    corners[4] = 32'd1;
    corners[5] = 32'h1234_5678;
    for (int k = 0; k < 6; k++)
      for (int i = 0; i < 6; i++)
        for (int j = 0; j < 6; j++)
          apply_big(k, corners[i], corners[j]);

    // Pseudo-random operands, including equal pairs
    lfsr_a = 32'hACE1_2468;
    lfsr_b = 32'h1357_9BDF;
    for (int n = 0; n < 300; n++) begin
      lfsr_a = {lfsr_a[30:0], lfsr_a[31] ^ lfsr_a[21] ^ lfsr_a[1] ^ lfsr_a[0]};
      lfsr_b = lfsr_b * 32'd1664525 + 32'd1013904223;
      for (int k = 0; k < 6; k++) begin
        apply_big(k, lfsr_a, lfsr_b);
        apply_big(k, lfsr_a, lfsr_a);
      end
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule